// File: doc/BRIEF.md
# Kernel SVM Classifier Datapath

This block decides which side of a trained decision boundary one test feature vector falls on. The test vector and a single support-vector model live in two external buffers that share one read address. The block fetches both element by element. Each 32-bit signed Q16.16 element is built from two 16-bit reads, with the upper half read first. One pipelined multiplier and one saturating accumulator evaluate the chosen kernel. The linear kernel is the plain dot product. The quadratic kernel is the dot product plus one, squared, and the squaring reuses the same multiplier. A bias is then added and the signed score is latched in an output register. The sign bit of that register is the class.

A classification begins with a one-cycle `start` pulse while the block is idle. The kernel choice and the bias are captured on that same cycle. `busy` stays high until the result is ready. A one-cycle `done` pulse marks the cycle in which the new score and class first appear. All arithmetic is fixed point, so no floating-point resources are required.

Top module: `svmk_classifier`

## Requirements
- R1: While and after reset, `busy`, `done`, `class_neg` and `score` are all 0.
- R2: Element i of both buffers is fetched from half-word address 2i (bits 31:16) and then from address 2i+1 (bits 15:0). `buf_rd` is high in every cycle that presents an address, and the buffer returns the data one clock after that address.
- R3: With `kern_quad`=0 the score is sat(D + bias). D is formed by saturating accumulation, from element 0 upward, of sat((x_i*w_i) >>> 16), where the shift is arithmetic.
- R4: With `kern_quad`=1 the score is sat(sat((s*s) >>> 16) + bias), where s = sat(D + 0x00010000). The squaring uses the same multiplier as the dot product.
- R5: Every product and every sum clamps to 0x7FFFFFFF above and to 0x80000000 below instead of wrapping.
- R6: `class_neg` equals bit 31 of `score`, so 1 means negative. A score of exactly zero gives `class_neg`=0.
- R7: `done` is high for exactly one cycle per classification, and `busy` is low in that cycle. `score` changes only in a cycle where `done` is high.
- R8: A `start` that arrives while `busy` is high has no effect. `kern_quad` and `bias` are sampled only on the cycle a start is accepted, and later changes do not alter the result.
- R9: `buf_rd` is never high while `busy` is low, and every address presented is below 2*N_FEAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to classify, accepted only when idle |
| kern_quad | input | 1 | Kernel select: 0 linear, 1 quadratic; sampled at start |
| bias | input | 32 | Signed Q16.16 bias; sampled at start |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | One-cycle pulse when score and class are updated |
| buf_rd | output | 1 | Read strobe for both buffers |
| buf_addr | output | $clog2(2*N_FEAT) | Half-word address shared by both buffers |
| vec_rdata | input | 16 | Test-vector buffer read data, one cycle after address |
| mdl_rdata | input | 16 | Model buffer read data, one cycle after address |
| score | output | 32 | Signed Q16.16 biased kernel score |
| class_neg | output | 1 | Class label: sign bit of score |

## Verification
The assertions take for granted that both buffers answer each address with data exactly one clock later, and that `start` is a single-cycle pulse. The bench memory model is a registered read that honours the one-clock timing. Starts are issued as single pulses, and any extra pulses are deliberately placed inside the busy window, so every accepted start is clean. Operand magnitudes are kept within ±4.0 for the random vectors. Directed vectors near the full range drive the saturation paths, and a zero-score case exercises the sign boundary.

// File: rtl/svmk_pkg.sv
package svmk_pkg;

    localparam int QW   = 32;
    localparam int HW   = 16;
    localparam int FRAC = 16;

    typedef logic signed [QW-1:0] q_t;

    localparam q_t Q_ONE = 32'sh0001_0000;
    localparam q_t Q_MAX = 32'sh7FFF_FFFF;
    localparam q_t Q_MIN = 32'sh8000_0000;

    typedef struct packed {
        q_t x;
        q_t w;
    } pair_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DOT,
        ST_SQ_ISSUE,
        ST_SQ_WAIT,
        ST_BIAS
    } st_e;

    function automatic q_t q_sat(input logic signed [63:0] v);
        if (v > 64'sh0000_0000_7FFF_FFFF)
            return Q_MAX;
        else if (v < -64'sh0000_0000_8000_0000)
            return Q_MIN;
        return v[QW-1:0];
    endfunction

    function automatic q_t q_add(input q_t a, input q_t b);
        logic signed [63:0] ea;
        logic signed [63:0] eb;
        ea = a;
        eb = b;
        return q_sat(ea + eb);
    endfunction

    function automatic q_t q_mul(input q_t a, input q_t b);
        logic signed [63:0] ea;
        logic signed [63:0] eb;
        logic signed [63:0] f;
        ea = a;
        eb = b;
        f  = ea * eb;
        return q_sat(f >>> FRAC);
    endfunction

endpackage

// File: rtl/svmk_fetch.sv
module svmk_fetch
    import svmk_pkg::*;
#(
    parameter int N_FEAT = 8,
    parameter int AW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    output logic          buf_rd,
    output logic [AW-1:0] buf_addr,
    input  logic [HW-1:0] vec_rdata,
    input  logic [HW-1:0] mdl_rdata,
    output pair_t         word,
    output logic          word_vld
);

    localparam logic [AW-1:0] LAST = AW'(2*N_FEAT-1);

    logic          active;
    logic [AW-1:0] idx;
    logic          rd_q;
    logic          lo_q;
    logic [HW-1:0] hi_x;
    logic [HW-1:0] hi_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            idx      <= '0;
            rd_q     <= 1'b0;
            lo_q     <= 1'b0;
            hi_x     <= '0;
            hi_w     <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            rd_q     <= active;
            lo_q     <= idx[0];
            word_vld <= 1'b0;
            if (go) begin
                active <= 1'b1;
                idx    <= '0;
            end else if (active) begin
                if (idx == LAST)
                    active <= 1'b0;
                idx <= idx + 1'b1;
            end
            if (rd_q) begin
                if (!lo_q) begin
                    hi_x <= vec_rdata;
                    hi_w <= mdl_rdata;
                end else begin
                    word.x   <= {hi_x, vec_rdata};
                    word.w   <= {hi_w, mdl_rdata};
                    word_vld <= 1'b1;
                end
            end
        end
    end

    assign buf_rd   = active;
    assign buf_addr = idx;

endmodule

// File: rtl/svmk_mult.sv
module svmk_mult
    import svmk_pkg::*;
#(
    parameter int MUL_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  q_t   a,
    input  q_t   b,
    input  logic in_vld,
    output q_t   p,
    output logic out_vld
);

    q_t   dat_pipe [MUL_LAT];
    logic vld_pipe [MUL_LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_pipe[0] <= 1'b0;
            dat_pipe[0] <= '0;
        end else begin
            vld_pipe[0] <= in_vld;
            dat_pipe[0] <= q_mul(a, b);
        end
    end

    for (genvar k = 1; k < MUL_LAT; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_pipe[k] <= 1'b0;
                dat_pipe[k] <= '0;
            end else begin
                vld_pipe[k] <= vld_pipe[k-1];
                dat_pipe[k] <= dat_pipe[k-1];
            end
        end
    end

    assign p       = dat_pipe[MUL_LAT-1];
    assign out_vld = vld_pipe[MUL_LAT-1];

endmodule

// File: rtl/svmk_accum.sv
module svmk_accum
    import svmk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic add,
    input  q_t   val,
    output q_t   sum
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum <= '0;
        else if (load)
            sum <= val;
        else if (add)
            sum <= q_add(sum, val);
    end

endmodule

// File: rtl/svmk_classifier.sv
module svmk_classifier
    import svmk_pkg::*;
#(
    parameter int N_FEAT  = 8,
    parameter int MUL_LAT = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          kern_quad,
    input  logic signed [31:0]            bias,
    output logic                          busy,
    output logic                          done,
    output logic                          buf_rd,
    output logic [$clog2(2*N_FEAT)-1:0]   buf_addr,
    input  logic [15:0]                   vec_rdata,
    input  logic [15:0]                   mdl_rdata,
    output logic signed [31:0]            score,
    output logic                          class_neg
);

    localparam int AW   = $clog2(2*N_FEAT);
    localparam int CNTW = $clog2(N_FEAT) + 1;
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(N_FEAT-1);

    st_e             state;
    logic            quad_r;
    q_t              bias_r;
    logic [CNTW-1:0] prod_cnt;

    logic  go;
    pair_t word;
    logic  word_vld;
    q_t    mul_a;
    q_t    mul_b;
    logic  mul_in_vld;
    q_t    mul_p;
    logic  mul_out_vld;
    q_t    acc;
    q_t    sq_operand;

    assign go = (state == ST_IDLE) && start;

    svmk_fetch #(.N_FEAT(N_FEAT), .AW(AW)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .buf_rd    (buf_rd),
        .buf_addr  (buf_addr),
        .vec_rdata (vec_rdata),
        .mdl_rdata (mdl_rdata),
        .word      (word),
        .word_vld  (word_vld)
    );

    assign sq_operand = q_add(acc, Q_ONE);

    always_comb begin
        if (state == ST_SQ_ISSUE) begin
            mul_a      = sq_operand;
            mul_b      = sq_operand;
            mul_in_vld = 1'b1;
        end else begin
            mul_a      = word.x;
            mul_b      = word.w;
            mul_in_vld = word_vld && (state == ST_DOT);
        end
    end

    svmk_mult #(.MUL_LAT(MUL_LAT)) u_mult (
        .clk     (clk),
        .rst     (rst),
        .a       (mul_a),
        .b       (mul_b),
        .in_vld  (mul_in_vld),
        .p       (mul_p),
        .out_vld (mul_out_vld)
    );

    svmk_accum u_accum (
        .clk  (clk),
        .rst  (rst),
        .clr  (go),
        .load ((state == ST_SQ_WAIT) && mul_out_vld),
        .add  ((state == ST_DOT) && mul_out_vld),
        .val  (mul_p),
        .sum  (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            quad_r   <= 1'b0;
            bias_r   <= '0;
            prod_cnt <= '0;
            score    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        quad_r   <= kern_quad;
                        bias_r   <= bias;
                        prod_cnt <= '0;
                        state    <= ST_DOT;
                    end
                end
                ST_DOT: begin
                    if (mul_out_vld) begin
                        prod_cnt <= prod_cnt + 1'b1;
                        if (prod_cnt == CNT_LAST)
                            state <= quad_r ? ST_SQ_ISSUE : ST_BIAS;
                    end
                end
                ST_SQ_ISSUE: state <= ST_SQ_WAIT;
                ST_SQ_WAIT: begin
                    if (mul_out_vld)
                        state <= ST_BIAS;
                end
                ST_BIAS: begin
                    score <= q_add(acc, bias_r);
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign class_neg = score[31];

endmodule

// File: rtl/svmk_chk.sv
module svmk_chk #(
    parameter int N_FEAT = 8,
    parameter int AW     = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                buf_rd,
    input logic [AW-1:0]       buf_addr,
    input logic signed [31:0]  score,
    input logic                class_neg
);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    score_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(score) |-> done);

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9
    rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
        buf_rd |-> busy);

    // R9
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        buf_rd |-> (32'(buf_addr) < 2*N_FEAT));

    // R6
    zero_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (score == 32'sd0) |-> !class_neg);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && score == 32'sd0));

endmodule

bind svmk_classifier svmk_chk #(.N_FEAT(N_FEAT), .AW($clog2(2*N_FEAT))) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .buf_rd    (buf_rd),
    .buf_addr  (buf_addr),
    .score     (score),
    .class_neg (class_neg)
);

// File: tb/tb_svmk_classifier.sv
module tb_svmk_classifier;

    localparam int N  = 8;
    localparam int AW = $clog2(2*N);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic               kern_quad = 1'b0;
    logic signed [31:0] bias = '0;
    logic               busy;
    logic               done;
    logic               buf_rd;
    logic [AW-1:0]      buf_addr;
    logic [15:0]        vec_rdata = '0;
    logic [15:0]        mdl_rdata = '0;
    logic signed [31:0] score;
    logic               class_neg;

    logic signed [31:0] xv [N];
    logic signed [31:0] wv [N];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    svmk_classifier #(.N_FEAT(N), .MUL_LAT(3)) dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .kern_quad (kern_quad),
        .bias      (bias),
        .busy      (busy),
        .done      (done),
        .buf_rd    (buf_rd),
        .buf_addr  (buf_addr),
        .vec_rdata (vec_rdata),
        .mdl_rdata (mdl_rdata),
        .score     (score),
        .class_neg (class_neg)
    );

    // buffer model: registered read, one clock after address (R2)
    always @(posedge clk) begin
        if (buf_rd) begin
            vec_rdata <= buf_addr[0] ? xv[int'(buf_addr >> 1)][15:0]
                                     : xv[int'(buf_addr >> 1)][31:16];
            mdl_rdata <= buf_addr[0] ? wv[int'(buf_addr >> 1)][15:0]
                                     : wv[int'(buf_addr >> 1)][31:16];
        end
    end

    function automatic longint sat(input longint v);
        if (v > 64'sd2147483647)
            return 64'sd2147483647;
        if (v < -64'sd2147483648)
            return -64'sd2147483648;
        return v;
    endfunction

    function automatic longint smul(input longint a, input longint b);
        longint p;
        p = a * b;
        return sat(p >>> 16);
    endfunction

    function automatic longint expect_score(input bit quad, input longint b);
        longint acc;
        longint s;
        acc = 0;
        for (int i = 0; i < N; i++)
            acc = sat(acc + smul(longint'(xv[i]), longint'(wv[i])));
        if (quad) begin
            s   = sat(acc + 65536);
            acc = smul(s, s);
        end
        return sat(acc + b);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [31:0] rnd_q();
        longint v;
        v = longint'($urandom_range(0, 8*65536)) - 4*65536;
        return 32'(v);
    endfunction

    task automatic run(input bit quad, input longint b, input bit perturb, input string req);
        longint exp;
        int     waitc;
        exp = expect_score(quad, b);
        @(negedge clk);
        kern_quad = quad;
        bias      = 32'(b);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (perturb) begin
            // R8: extra start and changed inputs while busy
            kern_quad = ~quad;
            bias      = 32'sh1234_5678;
            start     = 1'b1;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 500) begin
            @(negedge clk);
            waitc++;
        end
        chk(done == 1'b1, req, "done seen", longint'(done), 1);
        chk(longint'(score) == exp, req, "score", longint'(score), exp);
        chk(class_neg == (exp < 0), "R6", "class", longint'(class_neg), longint'(exp < 0));
        chk(busy == 1'b0, "R7", "busy at done", longint'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done width", longint'(done), 0);
        if (perturb) begin
            // R8: no second classification started by the ignored pulse
            for (int k = 0; k < 4; k++) @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R8", "no restart",
                longint'({busy, done}), 0);
            chk(longint'(score) == exp, "R8", "score kept", longint'(score), exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            xv[i] = '0;
            wv[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", longint'(busy), 0);
        chk(done == 1'b0, "R1", "done", longint'(done), 0);
        chk(class_neg == 1'b0, "R1", "class", longint'(class_neg), 0);
        chk(score == 32'sd0, "R1", "score", longint'(score), 0);
        rst = 1'b0;
        @(negedge clk);

        // R6 zero score is positive
        run(1'b0, 0, 1'b0, "R6");
        // R4 quadratic: s = 1.0, square 1.0, bias -1.0 gives zero
        run(1'b1, -65536, 1'b0, "R4");

        // R2 distinct halves so any swap or offset changes the result
        for (int i = 0; i < N; i++) begin
            xv[i] = 32'sh0001_8000 + 32'(i) * 32'sh0000_4001;
            wv[i] = 32'shFFFE_2000 - 32'(i) * 32'sh0000_0103;
        end
        run(1'b0, 12345, 1'b0, "R2");

        // R5 saturation high, linear and quadratic
        for (int i = 0; i < N; i++) begin
            xv[i] = 32'sh7FFF_0000;
            wv[i] = 32'sh7FFF_0000;
        end
        run(1'b0, -65536, 1'b0, "R5");
        run(1'b1, 0, 1'b0, "R5");
        // R5 saturation low
        for (int i = 0; i < N; i++) wv[i] = 32'sh8001_0000;
        run(1'b0, -100, 1'b0, "R5");
        run(1'b1, 3 * 65536, 1'b0, "R5");

        // R8 perturbed runs: extra start, flipped kernel and bias while busy
        for (int i = 0; i < N; i++) begin
            xv[i] = rnd_q();
            wv[i] = rnd_q();
        end
        run(1'b0, 65536, 1'b1, "R8");
        run(1'b1, -200000, 1'b1, "R8");

        // R3 / R4 random patterns
        for (int t = 0; t < 30; t++) begin
            for (int i = 0; i < N; i++) begin
                xv[i] = rnd_q();
                wv[i] = rnd_q();
            end
            if (t % 2 == 0)
                run(1'b0, longint'(rnd_q()), 1'b0, "R3");
            else
                run(1'b1, longint'(rnd_q()) * 8, 1'b0, "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule